// File: doc/BRIEF.md
# Signed/Unsigned Fractional Multiplier

This unit multiplies two operands of `OPW` bits (8 by default) and returns a product of twice that width. A three-bit variant code selects the operand signedness and whether the result is in integer or fractional form. The signedness can be unsigned by unsigned, signed by signed, or a signed first operand by an unsigned second operand. In fractional form the product is shifted left by one bit, so that two Q1.7 numbers give a Q1.15 result.

The caller pulses `start_i` with the operands and the variant code. Two clocks later the unit raises `done_o` for one cycle. In that cycle it presents the result as a low byte and a high byte, ready to be written into a fixed register pair, together with a zero flag and a carry flag. The unit is pipelined and accepts a new operation on every clock. Between results, all outputs keep their last values. This means the two flags behave like status bits that only this unit's operations change.

Top module: `frac_mult_unit`

## Requirements
- R1: Variant code bits [1:0] = 00 multiplies both operands as unsigned numbers; {prod_hi_o, prod_lo_o} equals opa_i * opb_i.
- R2: Bits [1:0] = 01 multiplies both operands as two's-complement numbers; the result is the low 2*OPW bits of the signed product.
- R3: Bits [1:0] = 10 sign-extends opa_i and zero-extends opb_i before multiplying.
- R4: Bit [2] = 1 selects fractional form: the 2*OPW-bit product is shifted left by one, bit 0 of the result is 0, and the product's top bit is dropped from the result.
- R5: The low OPW bits of the result appear on prod_lo_o and the high OPW bits on prod_hi_o.
- R6: flag_z_o is 1 exactly when the delivered result (after any fractional shift) is zero.
- R7: flag_c_o equals the top bit of the product before any fractional shift.
- R8: done_o is high for exactly one cycle, following the second rising edge counted from the edge that samples start_i high; results and flags are valid in that cycle.
- R9: While done_o is low, prod_lo_o, prod_hi_o, flag_z_o and flag_c_o keep their values.
- R10: A start on every consecutive clock gives a correct result on every consecutive clock, in issue order.
- R11: Synchronous active-high reset clears done_o, both product bytes and both flags.
- R12: Bits [1:0] = 11 behave as unsigned by unsigned, in either form.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch one multiply this cycle |
| mode_i | input | 3 | Variant: [2] fractional, [1:0] signedness |
| opa_i | input | OPW | First operand |
| opb_i | input | OPW | Second operand |
| prod_lo_o | output | OPW | Result low byte |
| prod_hi_o | output | OPW | Result high byte |
| flag_z_o | output | 1 | Zero flag of the result |
| flag_c_o | output | 1 | Top bit of unshifted product |
| done_o | output | 1 | Result valid pulse |

## Verification
The bench builds the unit with the default OPW = 8. At this width the extreme operands are all reachable by directed stimulus: 0x80 and 0xFF, which stress sign extension, and the fractional shift that moves the product's top bit out while it still sets carry. Random variant codes are mixed with random start gaps, including runs of back-to-back starts. These cover every signedness, both forms, the reserved code and full pipeline occupancy against a two-slot expected-value queue.

// File: rtl/fmul_pkg.sv
package fmul_pkg;
  typedef enum logic [1:0] {
    SGN_UU  = 2'b00,
    SGN_SS  = 2'b01,
    SGN_SU  = 2'b10,
    SGN_RSV = 2'b11
  } sign_mode_e;

  localparam int MODE_W = 3;
  localparam int FRAC_BIT = 2;
endpackage

// File: rtl/fmul_operand_prep.sv
module fmul_operand_prep
  import fmul_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  sign_mode_e      sm_i,
  output logic signed [W:0] a_x_o,
  output logic signed [W:0] b_x_o
);
  logic a_signed, b_signed;

  always_comb begin
    a_signed = (sm_i == SGN_SS) || (sm_i == SGN_SU);
    b_signed = (sm_i == SGN_SS);
    a_x_o = $signed({a_signed & a_i[W-1], a_i});
    b_x_o = $signed({b_signed & b_i[W-1], b_i});
  end
endmodule

// File: rtl/fmul_core.sv
module fmul_core #(
  parameter int W = 8,
  localparam int PW = 2 * W
) (
  input  logic signed [W:0] a_i,
  input  logic signed [W:0] b_i,
  output logic [PW-1:0]     p_o
);
  logic signed [PW-1:0] a_e, b_e, prod;

  always_comb begin
    a_e  = PW'(a_i);
    b_e  = PW'(b_i);
    prod = a_e * b_e;
    p_o  = prod;
  end
endmodule

// File: rtl/fmul_result_fmt.sv
module fmul_result_fmt #(
  parameter int W = 8,
  localparam int PW = 2 * W
) (
  input  logic [PW-1:0] raw_i,
  input  logic          frac_i,
  output logic [PW-1:0] res_o,
  output logic          z_o,
  output logic          c_o
);
  always_comb begin
    res_o = frac_i ? {raw_i[PW-2:0], 1'b0} : raw_i;
    z_o   = (res_o == '0);
    c_o   = raw_i[PW-1];
  end
endmodule

// File: rtl/frac_mult_unit.sv
module frac_mult_unit
  import fmul_pkg::*;
#(
  parameter int OPW = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic [MODE_W-1:0]    mode_i,
  input  logic [OPW-1:0]       opa_i,
  input  logic [OPW-1:0]       opb_i,
  output logic [OPW-1:0]       prod_lo_o,
  output logic [OPW-1:0]       prod_hi_o,
  output logic                 flag_z_o,
  output logic                 flag_c_o,
  output logic                 done_o
);
  localparam int PW = 2 * OPW;

  sign_mode_e sm_in;
  logic signed [OPW:0] a_x, b_x;
  logic signed [OPW:0] a_q, b_q;
  logic frac_q, vld_q;
  logic [PW-1:0] raw_p, res_p;
  logic z_n, c_n;

  assign sm_in = sign_mode_e'(mode_i[1:0]);

  fmul_operand_prep #(.W(OPW)) u_prep (
    .a_i(opa_i), .b_i(opb_i), .sm_i(sm_in), .a_x_o(a_x), .b_x_o(b_x)
  );

  // stage 1: extended operands
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      frac_q <= 1'b0;
      a_q    <= '0;
      b_q    <= '0;
    end else begin
      vld_q <= start_i;
      if (start_i) begin
        frac_q <= mode_i[FRAC_BIT];
        a_q    <= a_x;
        b_q    <= b_x;
      end
    end
  end

  fmul_core #(.W(OPW)) u_core (.a_i(a_q), .b_i(b_q), .p_o(raw_p));

  fmul_result_fmt #(.W(OPW)) u_fmt (
    .raw_i(raw_p), .frac_i(frac_q), .res_o(res_p), .z_o(z_n), .c_o(c_n)
  );

  // stage 2: registered results, held between operations
  always_ff @(posedge clk) begin
    if (rst) begin
      done_o    <= 1'b0;
      prod_lo_o <= '0;
      prod_hi_o <= '0;
      flag_z_o  <= 1'b0;
      flag_c_o  <= 1'b0;
    end else begin
      done_o <= vld_q;
      if (vld_q) begin
        prod_lo_o <= res_p[OPW-1:0];
        prod_hi_o <= res_p[PW-1:OPW];
        flag_z_o  <= z_n;
        flag_c_o  <= c_n;
      end
    end
  end
endmodule

// File: rtl/fmul_chk.sv
module fmul_chk #(
  parameter int OPW = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           start_i,
  input logic [2:0]     mode_i,
  input logic [OPW-1:0] opa_i,
  input logic [OPW-1:0] opb_i,
  input logic [OPW-1:0] prod_lo_o,
  input logic [OPW-1:0] prod_hi_o,
  input logic           flag_z_o,
  input logic           flag_c_o,
  input logic           done_o
);
  // R8
  done_after_start_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |=> ##1 done_o);

  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable({prod_hi_o, prod_lo_o, flag_z_o, flag_c_o}));

  // R4
  frac_lsb_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && $past(mode_i[2], 2)) |-> (prod_lo_o[0] == 1'b0));

  // R1
  uu_product_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && $past(mode_i, 2) == 3'b000) |->
      ({prod_hi_o, prod_lo_o} == (2*OPW)'($past(opa_i, 2)) * (2*OPW)'($past(opb_i, 2))));

  // R6
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (flag_z_o == ({prod_hi_o, prod_lo_o} == '0)));

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!done_o && !flag_z_o && !flag_c_o && prod_lo_o == '0 && prod_hi_o == '0));
endmodule

bind frac_mult_unit fmul_chk #(.OPW(OPW)) u_fmul_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
  .opa_i(opa_i), .opb_i(opb_i), .prod_lo_o(prod_lo_o), .prod_hi_o(prod_hi_o),
  .flag_z_o(flag_z_o), .flag_c_o(flag_c_o), .done_o(done_o)
);

// File: tb/test_frac_mult_unit.sv
`timescale 1ns/1ps
module test_frac_mult_unit;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [2:0] mode_i = '0;
  logic [W-1:0] opa_i = '0, opb_i = '0;
  logic [W-1:0] prod_lo_o, prod_hi_o;
  logic flag_z_o, flag_c_o, done_o;

  int n_tests = 0;
  int n_fail = 0;

  // expected-result slots: {valid, mode, c, z, result}
  logic p1_v = 0, p2_v = 0;
  logic [2:0] p1_m = 0, p2_m = 0;
  logic [17:0] p1_e = 0, p2_e = 0;
  logic [17:0] last_e = 0;

  always #2.5 clk = ~clk;

  frac_mult_unit #(.OPW(W)) i_frac_mult_unit (
    .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
    .opa_i(opa_i), .opb_i(opb_i), .prod_lo_o(prod_lo_o), .prod_hi_o(prod_hi_o),
    .flag_z_o(flag_z_o), .flag_c_o(flag_c_o), .done_o(done_o)
  );

  // returns {c, z, result}
  function automatic logic [17:0] ref_mul(input logic [2:0] m, input logic [7:0] a, input logic [7:0] b);
    int sa, sb, p;
    logic [15:0] raw, res;
    sa = (m[1:0] == 2'b01 || m[1:0] == 2'b10) ? int'($signed(a)) : int'(a);
    sb = (m[1:0] == 2'b01) ? int'($signed(b)) : int'(b);
    p = sa * sb;
    raw = p[15:0];
    res = m[2] ? (raw << 1) : raw;
    return {raw[15], (res == 16'h0), res};
  endfunction

  function automatic string req_of(input logic [2:0] m);
    string s;
    case (m[1:0])
      2'b00: s = "R1";
      2'b01: s = "R2";
      2'b10: s = "R3";
      default: s = "R12";
    endcase
    if (m[2]) s = {s, "/R4"};
    return s;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge: check slot issued two negedges ago, then shift
  task automatic step(input logic s, input logic [2:0] m, input logic [7:0] a, input logic [7:0] b);
    chk("R8 done", 32'(done_o), 32'(p2_v));
    if (p2_v) begin
      chk({req_of(p2_m), "/R5 product"}, 32'({prod_hi_o, prod_lo_o}), 32'(p2_e[15:0]));
      chk("R6 zero flag", 32'(flag_z_o), 32'(p2_e[16]));
      chk("R7 carry flag", 32'(flag_c_o), 32'(p2_e[17]));
      last_e = p2_e;
    end else begin
      chk("R9 hold", 32'({flag_c_o, flag_z_o, prod_hi_o, prod_lo_o}), 32'(last_e));
    end
    p2_v = p1_v; p2_m = p1_m; p2_e = p1_e;
    p1_v = s; p1_m = m; p1_e = ref_mul(m, a, b);
    start_i = s; mode_i = m; opa_i = a; opb_i = b;
  endtask

  task automatic go(input logic [2:0] m, input logic [7:0] a, input logic [7:0] b);
    @(negedge clk); step(1'b1, m, a, b);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); step(1'b0, 3'b000, $urandom, $urandom);
    end
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    // R11: outputs cleared during reset
    chk("R11 reset", 32'({done_o, flag_c_o, flag_z_o, prod_hi_o, prod_lo_o}), 32'h0);
    rst = 1'b0;

    // directed corners, spaced out
    go(3'b000, 8'hFF, 8'hFF); idle(3);      // 0xFE01, C=1
    go(3'b100, 8'hFF, 8'hFF); idle(3);      // 0xFC02, C=1
    go(3'b001, 8'h80, 8'h80); idle(3);      // 0x4000
    go(3'b101, 8'h80, 8'h80); idle(3);      // 0x8000, C=0
    go(3'b001, 8'hFF, 8'hFF); idle(3);      // 0x0001
    go(3'b010, 8'hFF, 8'hFF); idle(3);      // 0xFF01, C=1
    go(3'b110, 8'h80, 8'hFF); idle(3);      // 0x0100, C=1
    go(3'b010, 8'h00, 8'h9C); idle(3);      // zero, Z=1
    go(3'b101, 8'h00, 8'h80); idle(3);      // zero fractional, Z=1
    go(3'b011, 8'hFF, 8'h80); idle(3);      // R12 reserved as UU
    go(3'b111, 8'hC3, 8'h81); idle(3);      // R12 reserved fractional

    // R10: back-to-back burst
    go(3'b001, 8'h7F, 8'h81);
    go(3'b010, 8'h81, 8'h7F);
    go(3'b100, 8'h12, 8'h34);
    go(3'b110, 8'hFE, 8'h02);
    idle(4);

    // random mix with random gaps
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      step(($urandom % 10) < 7, 3'($urandom), 8'($urandom), 8'($urandom));
    end
    idle(4);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule